// File: doc/BRIEF.md
# Cascadable 8/16-bit Pulse Generator

This block produces a continuous rectangular wave on each of four outputs. Every channel has its own down-counter and two reload values. One value sets how long the output stays low and the other sets how long it stays high, so period and duty are set independently. All counters advance on a common count tick. A shared prescaler derives that tick from the machine clock by dividing it by 1 to 16.

Two neighbouring channels can be joined at run time into one 16-bit channel. The even channel then supplies the low byte of the count and of both reload values, and the odd channel supplies the high byte. The odd counter moves only when the even counter wraps, and the pair drives only the even output. Each channel can also raise a one-cycle interrupt pulse at the end of every full period.

Software configures the block through a single registered write port. Bus decoding and pin multiplexing are handled outside the block.

Top module: `cascade_pulse_gen`

## Requirements
- R1: After reset, all pulse and interrupt outputs are low, all reload values and controls are zero, and the prescaler select is 0.
- R2: A write is addressed as wr_addr_i = {kind[1:0], channel[1:0]}. Kind 0 writes the low-time value and kind 1 the high-time value. Kind 2 writes the control byte: bit 0 enable, bit 1 interrupt enable, bit 2 pairing (honoured on even channels only). Kind 3 writes the prescaler select from the low 4 data bits, and the channel field is ignored. A written value is in effect from the next clock edge.
- R3: An enabled unpaired channel with low value L and high value H outputs a continuous wave: high for H+1 count ticks, then low for L+1 count ticks. Values of 0 give one-tick phases.
- R4: With prescaler select S, a count tick occurs every S+1 machine clock cycles, for S from 0 to 15.
- R5: With pairing set on an even channel, the pair acts as one 16-bit channel. Its low value is {odd low, even low} and its high value is {odd high, even high}. The even output is high for the 16-bit high value + 1 ticks and low for the 16-bit low value + 1 ticks.
- R6: While a pair is joined, the odd output and the odd interrupt stay low, and the odd channel's control byte has no effect.
- R7: A reload value written during a phase does not change the length of that phase. It applies from the next reload point.
- R8: Clearing enable drives the output low on the next clock edge and clears the counter. On re-enable, the output goes high at the first count tick.
- R9: With interrupt enable set, the interrupt output pulses for exactly one cycle, together with each low-to-high output transition except the first one after enabling. With interrupt enable clear, it stays low.
- R10: Changing a pairing bit clears both channels of that pair, so both outputs are low on the second clock edge after the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Machine clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 4 | Write address {kind, channel} |
| wr_data_i | input | 8 | Write data |
| pulse_o | output | 4 | Pulse output per channel |
| irq_o | output | 4 | One-cycle end-of-period interrupt per channel |

## Verification
Some properties hold cycle by cycle, and the assertions check them on every clock:
- a disabled channel is low after one edge;
- a joined odd channel stays silent;
- interrupts last one cycle and coincide with a rising output;
- counters hold between ticks;
- the prescaler never ticks twice in a row for a non-zero divide.

Phase lengths under different divides and reload values, the 16-bit cascade, the deferral of a reload written mid-phase, and restarts after disable or re-pairing are visible only over whole waveforms. The directed bench scenarios cover these.

// File: rtl/cpg_pkg.sv
package cpg_pkg;
    typedef struct packed {
        logic pair;
        logic irq_en;
        logic en;
    } cpg_ctrl_t;

    localparam logic [1:0] KIND_LOW  = 2'd0;
    localparam logic [1:0] KIND_HIGH = 2'd1;
    localparam logic [1:0] KIND_CTRL = 2'd2;
    localparam logic [1:0] KIND_PRE  = 2'd3;
endpackage

// File: rtl/cpg_regs.sv
module cpg_regs
    import cpg_pkg::*;
#(
    parameter int NCH = 4,
    parameter int CW  = 8,
    parameter int PSW = 4,
    localparam int CHW = $clog2(NCH),
    localparam int AW  = CHW + 2
) (
    input  logic                     clk_i,
    input  logic                     rst_ni,
    input  logic                     wr_en_i,
    input  logic [AW-1:0]            wr_addr_i,
    input  logic [CW-1:0]            wr_data_i,
    output logic [NCH-1:0][CW-1:0]   lo_o,
    output logic [NCH-1:0][CW-1:0]   hi_o,
    output cpg_ctrl_t [NCH-1:0]      ctrl_o,
    output logic [PSW-1:0]           pre_o
);
    typedef struct packed {
        logic [NCH-1:0][CW-1:0] lo;
        logic [NCH-1:0][CW-1:0] hi;
        cpg_ctrl_t [NCH-1:0]    ctrl;
        logic [PSW-1:0]         pre;
    } regs_t;

    regs_t r_q, r_d;
    logic [1:0]     kind;
    logic [CHW-1:0] ch;

    assign kind = wr_addr_i[AW-1:CHW];
    assign ch   = wr_addr_i[CHW-1:0];

    always_comb begin
        r_d = r_q;
        if (wr_en_i) begin
            case (kind)
                KIND_LOW:  r_d.lo[ch]   = wr_data_i;
                KIND_HIGH: r_d.hi[ch]   = wr_data_i;
                KIND_CTRL: r_d.ctrl[ch] = wr_data_i[2:0];
                default:   r_d.pre      = wr_data_i[PSW-1:0];
            endcase
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) r_q <= '0;
        else         r_q <= r_d;
    end

    assign lo_o   = r_q.lo;
    assign hi_o   = r_q.hi;
    assign ctrl_o = r_q.ctrl;
    assign pre_o  = r_q.pre;
endmodule

// File: rtl/cpg_prescale.sv
module cpg_prescale #(
    parameter int PSW = 4
) (
    input  logic           clk_i,
    input  logic           rst_ni,
    input  logic [PSW-1:0] sel_i,
    output logic           tick_o
);
    typedef struct packed {
        logic [PSW-1:0] cnt;
    } pre_t;

    pre_t p_q, p_d;

    assign tick_o = (p_q.cnt >= sel_i);

    always_comb begin
        p_d = p_q;
        if (tick_o) p_d.cnt = '0;
        else        p_d.cnt = p_q.cnt + 1'b1;
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) p_q <= '0;
        else         p_q <= p_d;
    end

    // R4
    tick_spacing_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (tick_o && sel_i != '0) |=> (!tick_o || sel_i != $past(sel_i)));
endmodule

// File: rtl/cpg_pair.sv
module cpg_pair
    import cpg_pkg::*;
#(
    parameter int CW = 8
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          tick_i,
    input  cpg_ctrl_t     ctrl_e_i,
    input  cpg_ctrl_t     ctrl_o_i,
    input  logic [CW-1:0] lo_e_i,
    input  logic [CW-1:0] hi_e_i,
    input  logic [CW-1:0] lo_o_i,
    input  logic [CW-1:0] hi_o_i,
    output logic          out_e_o,
    output logic          out_o_o,
    output logic          irq_e_o,
    output logic          irq_o_o
);
    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          out;
        logic          run;
        logic          irq;
    } lane_t;

    typedef struct packed {
        lane_t ev;
        lane_t od;
        logic  pair;
    } st_t;

    st_t s_q, s_d;
    logic [2*CW-1:0] wide_q;

    assign wide_q = {s_q.od.cnt, s_q.ev.cnt};

    function automatic lane_t lane_step(lane_t cur, cpg_ctrl_t c, logic tk,
                                        logic [CW-1:0] lo, logic [CW-1:0] hi);
        lane_t nx;
        nx     = cur;
        nx.irq = 1'b0;
        if (!c.en) begin
            nx = '0;
        end else if (tk) begin
            if (cur.cnt == '0) begin
                nx.out = ~cur.out;
                nx.cnt = cur.out ? lo : hi;
                nx.irq = c.irq_en & cur.run & ~cur.out;
                nx.run = 1'b1;
            end else begin
                nx.cnt = cur.cnt - 1'b1;
            end
        end
        return nx;
    endfunction

    always_comb begin
        s_d        = s_q;
        s_d.pair   = ctrl_e_i.pair;
        s_d.ev.irq = 1'b0;
        s_d.od.irq = 1'b0;
        if (ctrl_e_i.pair != s_q.pair) begin
            s_d.ev = '0;
            s_d.od = '0;
        end else if (s_q.pair) begin
            s_d.od.out = 1'b0;
            s_d.od.run = 1'b0;
            if (!ctrl_e_i.en) begin
                s_d.ev     = '0;
                s_d.od.cnt = '0;
            end else if (tick_i) begin
                if (wide_q == '0) begin
                    s_d.ev.out = ~s_q.ev.out;
                    {s_d.od.cnt, s_d.ev.cnt} = s_q.ev.out ? {lo_o_i, lo_e_i}
                                                          : {hi_o_i, hi_e_i};
                    s_d.ev.irq = ctrl_e_i.irq_en & s_q.ev.run & ~s_q.ev.out;
                    s_d.ev.run = 1'b1;
                end else begin
                    s_d.ev.cnt = s_q.ev.cnt - 1'b1;
                    if (s_q.ev.cnt == '0) s_d.od.cnt = s_q.od.cnt - 1'b1;
                end
            end
        end else begin
            s_d.ev = lane_step(s_q.ev, ctrl_e_i, tick_i, lo_e_i, hi_e_i);
            s_d.od = lane_step(s_q.od, ctrl_o_i, tick_i, lo_o_i, hi_o_i);
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) s_q <= '0;
        else         s_q <= s_d;
    end

    assign out_e_o = s_q.ev.out;
    assign out_o_o = s_q.od.out;
    assign irq_e_o = s_q.ev.irq;
    assign irq_o_o = s_q.od.irq;

    // R8
    off_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !ctrl_e_i.en |=> !out_e_o);

    // R6
    odd_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (ctrl_e_i.pair && s_q.pair) |-> (!out_o_o && !irq_o_o));

    // R9
    irq_width_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        irq_e_o |=> !irq_e_o);

    // R9
    irq_edge_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        irq_e_o |-> $rose(out_e_o));

    // R7
    hold_between_ticks_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!tick_i && ctrl_e_i.en && ctrl_e_i.pair == s_q.pair) |=> $stable(s_q.ev.cnt));
endmodule

// File: rtl/cascade_pulse_gen.sv
module cascade_pulse_gen
    import cpg_pkg::*;
#(
    parameter int NCH = 4,
    parameter int CW  = 8,
    parameter int PSW = 4,
    localparam int CHW   = $clog2(NCH),
    localparam int AW    = CHW + 2,
    localparam int NPAIR = NCH / 2
) (
    input  logic           clk_i,
    input  logic           rst_ni,
    input  logic           wr_en_i,
    input  logic [AW-1:0]  wr_addr_i,
    input  logic [CW-1:0]  wr_data_i,
    output logic [NCH-1:0] pulse_o,
    output logic [NCH-1:0] irq_o
);
    logic [NCH-1:0][CW-1:0] lo, hi;
    cpg_ctrl_t [NCH-1:0]    ctrl;
    logic [PSW-1:0]         pre;
    logic                   tick;

    cpg_regs #(.NCH(NCH), .CW(CW), .PSW(PSW)) u_regs (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .wr_en_i   (wr_en_i),
        .wr_addr_i (wr_addr_i),
        .wr_data_i (wr_data_i),
        .lo_o      (lo),
        .hi_o      (hi),
        .ctrl_o    (ctrl),
        .pre_o     (pre)
    );

    cpg_prescale #(.PSW(PSW)) u_pre (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .sel_i  (pre),
        .tick_o (tick)
    );

    for (genvar p = 0; p < NPAIR; p++) begin : g_pair
        cpg_pair #(.CW(CW)) u_pair (
            .clk_i    (clk_i),
            .rst_ni   (rst_ni),
            .tick_i   (tick),
            .ctrl_e_i (ctrl[2*p]),
            .ctrl_o_i (ctrl[2*p+1]),
            .lo_e_i   (lo[2*p]),
            .hi_e_i   (hi[2*p]),
            .lo_o_i   (lo[2*p+1]),
            .hi_o_i   (hi[2*p+1]),
            .out_e_o  (pulse_o[2*p]),
            .out_o_o  (pulse_o[2*p+1]),
            .irq_e_o  (irq_o[2*p]),
            .irq_o_o  (irq_o[2*p+1])
        );
    end
endmodule

// File: tb/cascade_pulse_gen_test.sv
module cascade_pulse_gen_test;
    logic       clk = 1'b0;
    logic       rst_n;
    logic       wr_en;
    logic [3:0] wr_addr;
    logic [7:0] wr_data;
    logic [3:0] pulse, irq;

    int n_chk  = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    cascade_pulse_gen uut (
        .clk_i     (clk),
        .rst_ni    (rst_n),
        .wr_en_i   (wr_en),
        .wr_addr_i (wr_addr),
        .wr_data_i (wr_data),
        .pulse_o   (pulse),
        .irq_o     (irq)
    );

    task automatic check(string req, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wr(int kind, int ch, int data);
        @(negedge clk);
        wr_en   = 1'b1;
        wr_addr = 4'(kind * 4 + ch);
        wr_data = 8'(data);
        @(negedge clk);
        wr_en   = 1'b0;
    endtask

    // measure one full high phase then the following low phase, in clocks
    task automatic measure(int ch, output int hi_len, output int lo_len);
        int guard = 0;
        hi_len = 0;
        lo_len = 0;
        while (pulse[ch] && guard < 5000) begin @(negedge clk); guard++; end
        while (!pulse[ch] && guard < 5000) begin @(negedge clk); guard++; end
        while (pulse[ch] && guard < 5000) begin hi_len++; @(negedge clk); guard++; end
        while (!pulse[ch] && guard < 5000) begin lo_len++; @(negedge clk); guard++; end
    endtask

    task automatic t_reset();
        check("R1 pulse after reset", int'(pulse), 0);
        check("R1 irq after reset", int'(irq), 0);
    endtask

    task automatic t_basic();
        int h, l;
        wr(3, 0, 0);
        wr(0, 0, 3); wr(1, 0, 1); wr(2, 0, 1);
        wr(0, 1, 0); wr(1, 1, 0); wr(2, 1, 1);
        measure(0, h, l);
        check("R3 ch0 high", h, 2);
        check("R3 ch0 low", l, 4);
        measure(1, h, l);
        check("R3 ch1 zero-value high", h, 1);
        check("R2 R3 ch1 zero-value low", l, 1);
    endtask

    task automatic t_prescale();
        int h, l;
        wr(3, 0, 3);
        measure(0, h, l);
        check("R4 div4 high", h, 8);
        check("R4 div4 low", l, 16);
        wr(3, 0, 15);
        measure(1, h, l);
        check("R4 div16 high", h, 16);
        check("R4 div16 low", l, 16);
        wr(3, 0, 0);
    endtask

    task automatic t_reload_defer();
        int h = 0, l, guard = 0;
        wr(0, 2, 10); wr(1, 2, 20); wr(2, 2, 1);
        while (pulse[2] && guard < 500) begin @(negedge clk); guard++; end
        while (!pulse[2] && guard < 500) begin @(negedge clk); guard++; end
        wr_en = 1'b1; wr_addr = 4'(1 * 4 + 2); wr_data = 8'd5;
        while (pulse[2] && guard < 500) begin
            h++; @(negedge clk); wr_en = 1'b0; guard++;
        end
        check("R7 phase in progress keeps old length", h, 21);
        measure(2, h, l);
        check("R7 next high phase uses new value", h, 6);
        check("R7 low phase", l, 11);
    endtask

    task automatic t_disable();
        int bad = 0;
        wr(0, 0, 200); wr(1, 0, 200); wr(2, 0, 1);
        repeat (50) @(negedge clk);
        wr(2, 0, 0);
        @(negedge clk);
        check("R8 low after disable", int'(pulse[0]), 0);
        for (int i = 0; i < 300; i++) begin
            if (pulse[0] || irq[0]) bad++;
            @(negedge clk);
        end
        check("R8 stays low while disabled", bad, 0);
        wr(2, 0, 1);
        check("R8 still low one edge after enable", int'(pulse[0]), 0);
        @(negedge clk);
        check("R8 high at first tick after re-enable", int'(pulse[0]), 1);
    endtask

    task automatic t_irq();
        int rises = 0, pulses = 0, wide = 0, prev_p, prev_i = 0;
        wr(2, 0, 0);
        wr(0, 0, 2); wr(1, 0, 1);
        wr(2, 0, 3);
        prev_p = int'(pulse[0]);
        for (int i = 0; i < 100; i++) begin
            @(negedge clk);
            if (pulse[0] && !prev_p) rises++;
            if (irq[0]) pulses++;
            if (irq[0] && prev_i) wide++;
            if (irq[0] && !(pulse[0] && !prev_p)) wide++;
            prev_p = int'(pulse[0]);
            prev_i = int'(irq[0]);
        end
        check("R9 one pulse per period except first", pulses, rises - 1);
        check("R9 single-cycle and on rising edge", wide, 0);
        wr(2, 0, 1);
        pulses = 0;
        for (int i = 0; i < 100; i++) begin
            @(negedge clk);
            if (irq[0]) pulses++;
        end
        check("R9 no pulse with irq enable clear", pulses, 0);
    endtask

    task automatic t_pair();
        int h, l, odd_act = 0;
        wr(2, 1, 3);
        wr(0, 0, 8'h2C); wr(0, 1, 8'h01);
        wr(1, 0, 8'h63); wr(1, 1, 8'h00);
        wr(2, 0, 5);
        @(negedge clk);
        check("R10 both outputs cleared after pairing change", int'(pulse[1:0]), 0);
        measure(0, h, l);
        check("R5 16-bit high", h, 100);
        check("R5 16-bit low", l, 301);
        for (int i = 0; i < 800; i++) begin
            if (pulse[1] || irq[1]) odd_act++;
            @(negedge clk);
        end
        check("R6 odd channel silent while joined", odd_act, 0);
    endtask

    initial begin
        #2000000;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

    initial begin
        rst_n   = 1'b0;
        wr_en   = 1'b0;
        wr_addr = '0;
        wr_data = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_basic();
        t_prescale();
        t_reload_defer();
        t_disable();
        t_irq();
        t_pair();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end
endmodule